// File: doc/BRIEF.md
# Multiplexed LCD Display RAM Writer

This block stores display data bytes in a column-organised display RAM. Every column holds a 4-bit word, one bit per backplane row. A command decoder upstream delivers one-cycle strobes: a pointer load, a device select, an abort, and data bytes with a valid flag. The selected multiplex mode decides how the eight bits of each byte are spread. In static mode the bits run along row 0 only. In the 1:2, 1:3 and 1:4 modes they fill two, three or four rows of each column before moving on to the next column.

A column pointer marks where the next byte lands. It moves forward by the number of columns the byte occupied, and it wraps modulo the column count. When a byte crosses the last column, its remaining bits continue from column 0. Several of these blocks can share one byte stream in a cascade. Each instance holds a subaddress counter and stores data only while that counter equals its own hardware subaddress pins. Its pointer advances in step with the others either way. Each time the pointer wraps, the counter moves on, so a long stream flows from one device into the next. A combinational read port exposes any column.

Top module: `lcd_ram_writer`

## Requirements
- R1: Mode code 0 (static): bit 7 of the byte goes to row 0 of column P, bit 6 to row 0 of column P+1, and so on down to bit 0 in row 0 of column P+7. No other row changes.
- R2: Mode code 1 (1:2): the bits go two per column, most significant first. Bit 7 goes to row 0 and bit 6 to row 1 of column P, then bits 5 and 4 go to column P+1, up to column P+3.
- R3: Mode code 2 (1:3): the bits go three per column into rows 0..2 of columns P, P+1 and P+2. Bits 1 and 0 land in rows 0 and 1 of column P+2, and row 2 of that column keeps its previous value. Row 3 is never written in this mode.
- R4: Mode code 3 (1:4): bits 7..4 go to rows 0..3 of column P and bits 3..0 to rows 0..3 of column P+1.
- R5: A pointer load sets P to ptr_val_i, which must be below NCOLS. After each accepted byte, P advances by 8, 4, 3 or 2 columns for mode codes 0, 1, 2 and 3. The advance is taken modulo NCOLS.
- R6: A device select loads the subaddress counter from dev_val_i. An accepted byte is written only when the counter equals hw_sub_i. Otherwise nothing in the RAM changes, but P still advances as in R5.
- R7: When an accepted byte wraps P past column NCOLS-1, its remaining bits continue from column 0. The subaddress counter increments by one, modulo 2^SUB_W, at the same time.
- R8: An abort makes the pointer invalid. Bytes that arrive while the pointer is invalid change neither the RAM nor P, until the next pointer load.
- R9: A data byte that arrives in the same cycle as a pointer load, a device select or an abort is discarded. The pointer load and the device select both take effect, and an abort takes priority over a pointer load.
- R10: After reset, every RAM bit is 0, the pointer is invalid and the subaddress counter is 0.
- R11: rd_data_o shows, combinationally, the word at column rd_addr_i, with row r on bit r. A write becomes visible after the clock edge that accepts the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Multiplex mode: 0 static, 1 for 1:2, 2 for 1:3, 3 for 1:4 |
| ptr_load_i | input | 1 | Pointer load strobe |
| ptr_val_i | input | PTR_W (6) | Pointer load value, below NCOLS |
| dev_sel_i | input | 1 | Device select strobe |
| dev_val_i | input | SUB_W (3) | Subaddress counter load value |
| hw_sub_i | input | SUB_W (3) | Hardware subaddress of this instance |
| byte_valid_i | input | 1 | A data byte is present on byte_i |
| byte_i | input | 8 | Display data byte |
| abort_i | input | 1 | Stream aborted; invalidates the pointer |
| rd_addr_i | input | PTR_W (6) | Read column |
| rd_data_o | output | 4 | Word at rd_addr_i, row r on bit r |

## Verification
The properties assume that the pointer load value is below NCOLS and that hw_sub_i is held steady. They also assume that mode_i does not change in a cycle that carries a data byte. The stimulus meets these conditions: it changes mode and loads only on cycles without bytes, uses load values inside the column range and ties hw_sub_i to one constant. Strobes are combined on purpose only in the cycles that exercise the discard rule. In those cycles every load value stays legal.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;

   localparam int BYTE_BITS = 8;
   localparam int LCD_ROWS  = 4;

   typedef enum logic [1:0] {
      MUX_STATIC = 2'd0,
      MUX_2      = 2'd1,
      MUX_3      = 2'd2,
      MUX_4      = 2'd3
   } mux_mode_e;

   // columns consumed by one byte in a given mode
   function automatic logic [3:0] cols_per_byte(input mux_mode_e m);
      case (m)
         MUX_STATIC: cols_per_byte = 4'd8;
         MUX_2:      cols_per_byte = 4'd4;
         MUX_3:      cols_per_byte = 4'd3;
         default:    cols_per_byte = 4'd2;
      endcase
   endfunction

endpackage

// File: rtl/lcd_bit_place.sv
module lcd_bit_place
   import lcd_wr_pkg::*;
#(
   parameter int NCOLS = 40,
   parameter int PTR_W = 6
) (
   input  logic [PTR_W-1:0]                 base_i,
   input  mux_mode_e                        mode_i,
   output logic [BYTE_BITS-1:0][PTR_W-1:0]  col_o,
   output logic [BYTE_BITS-1:0][1:0]        row_o
);

   localparam int SW = PTR_W + 1;

   for (genvar k = 0; k < BYTE_BITS; k++) begin : g_bit
      // placement constants of bit position k (k = 0 is the byte MSB)
      localparam int OFF_S = k;
      localparam int OFF_2 = k / 2;
      localparam int OFF_3 = k / 3;
      localparam int OFF_4 = k / 4;
      localparam int ROW_2 = k % 2;
      localparam int ROW_3 = k % 3;
      localparam int ROW_4 = k % 4;

      logic [3:0]       off;
      logic [1:0]       row_k;
      logic [SW-1:0]    sum;
      logic [PTR_W-1:0] col_k;

      always_comb begin
         case (mode_i)
            MUX_STATIC: begin off = 4'(OFF_S); row_k = 2'd0;        end
            MUX_2:      begin off = 4'(OFF_2); row_k = 2'(ROW_2);   end
            MUX_3:      begin off = 4'(OFF_3); row_k = 2'(ROW_3);   end
            default:    begin off = 4'(OFF_4); row_k = 2'(ROW_4);   end
         endcase
         sum = {1'b0, base_i} + SW'(off);
         if (sum >= SW'(NCOLS))
            col_k = PTR_W'(sum - SW'(NCOLS));
         else
            col_k = sum[PTR_W-1:0];
      end

      assign col_o[k] = col_k;
      assign row_o[k] = row_k;
   end

endmodule

// File: rtl/lcd_ptr_seq.sv
module lcd_ptr_seq
   import lcd_wr_pkg::*;
#(
   parameter int NCOLS = 40,
   parameter int PTR_W = 6,
   parameter int SUB_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mux_mode_e        mode_i,
   input  logic             ptr_load_i,
   input  logic [PTR_W-1:0] ptr_val_i,
   input  logic             dev_sel_i,
   input  logic [SUB_W-1:0] dev_val_i,
   input  logic [SUB_W-1:0] hw_sub_i,
   input  logic             byte_valid_i,
   input  logic             abort_i,
   output logic [PTR_W-1:0] ptr_o,
   output logic             ptr_ok_o,
   output logic [SUB_W-1:0] sub_o,
   output logic             accept_o,
   output logic             store_o
);

   localparam int SW = PTR_W + 1;

   logic [PTR_W-1:0] ptr_q;
   logic             ok_q;
   logic [SUB_W-1:0] sub_q;
   logic [SW-1:0]    sum;
   logic             wrap;
   logic [PTR_W-1:0] ptr_nxt;

   assign accept_o = byte_valid_i & ok_q & ~abort_i & ~ptr_load_i & ~dev_sel_i;
   assign store_o  = accept_o & (sub_q == hw_sub_i);

   always_comb begin
      sum  = {1'b0, ptr_q} + SW'(cols_per_byte(mode_i));
      wrap = (sum >= SW'(NCOLS));
      if (wrap)
         ptr_nxt = PTR_W'(sum - SW'(NCOLS));
      else
         ptr_nxt = sum[PTR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         ok_q  <= 1'b0;
      end else if (abort_i) begin
         ok_q  <= 1'b0;
      end else if (ptr_load_i) begin
         ptr_q <= ptr_val_i;
         ok_q  <= 1'b1;
      end else if (accept_o) begin
         ptr_q <= ptr_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sub_q <= '0;
      else if (dev_sel_i)
         sub_q <= dev_val_i;
      else if (accept_o && wrap)
         sub_q <= sub_q + 1'b1;
   end

   assign ptr_o    = ptr_q;
   assign ptr_ok_o = ok_q;
   assign sub_o    = sub_q;

endmodule

// File: rtl/lcd_col_ram.sv
module lcd_col_ram
   import lcd_wr_pkg::*;
#(
   parameter int NCOLS = 40,
   parameter int PTR_W = 6
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we_i,
   input  logic [BYTE_BITS-1:0]             byte_i,
   input  logic [BYTE_BITS-1:0][PTR_W-1:0]  col_i,
   input  logic [BYTE_BITS-1:0][1:0]        row_i,
   input  logic [PTR_W-1:0]                 rd_addr_i,
   output logic [LCD_ROWS-1:0]              rd_data_o
);

   logic [NCOLS-1:0][LCD_ROWS-1:0] words;

   for (genvar c = 0; c < NCOLS; c++) begin : g_col
      for (genvar r = 0; r < LCD_ROWS; r++) begin : g_row
         logic cell_q;
         logic hit;
         logic din;

         always_comb begin
            hit = 1'b0;
            din = 1'b0;
            for (int k = 0; k < BYTE_BITS; k++) begin
               if (col_i[k] == PTR_W'(c) && row_i[k] == 2'(r)) begin
                  hit = 1'b1;
                  din = byte_i[BYTE_BITS-1-k];
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cell_q <= 1'b0;
            else if (we_i && hit)
               cell_q <= din;
         end

         assign words[c][r] = cell_q;
      end
   end

   always_comb begin
      rd_data_o = '0;
      for (int c = 0; c < NCOLS; c++)
         if (rd_addr_i == PTR_W'(c))
            rd_data_o = words[c];
   end

endmodule

// File: rtl/lcd_ram_writer.sv
module lcd_ram_writer
   import lcd_wr_pkg::*;
#(
   parameter  int NCOLS = 40,
   parameter  int SUB_W = 3,
   localparam int PTR_W = $clog2(NCOLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_i,
   input  logic             ptr_load_i,
   input  logic [PTR_W-1:0] ptr_val_i,
   input  logic             dev_sel_i,
   input  logic [SUB_W-1:0] dev_val_i,
   input  logic [SUB_W-1:0] hw_sub_i,
   input  logic             byte_valid_i,
   input  logic [7:0]       byte_i,
   input  logic             abort_i,
   input  logic [PTR_W-1:0] rd_addr_i,
   output logic [3:0]       rd_data_o
);

   if (NCOLS < BYTE_BITS) begin : g_bad_ncols
      $error("lcd_ram_writer: NCOLS must be at least one byte of columns");
   end
   if (SUB_W < 1) begin : g_bad_subw
      $error("lcd_ram_writer: SUB_W must be positive");
   end

   mux_mode_e mode;
   assign mode = mux_mode_e'(mode_i);

   logic [PTR_W-1:0]                ptr_q;
   logic                            ptr_ok_q;
   logic [SUB_W-1:0]                sub_q;
   logic                            accept;
   logic                            store_en;
   logic [BYTE_BITS-1:0][PTR_W-1:0] bit_col;
   logic [BYTE_BITS-1:0][1:0]       bit_row;

   lcd_ptr_seq #(.NCOLS(NCOLS), .PTR_W(PTR_W), .SUB_W(SUB_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode),
      .ptr_load_i  (ptr_load_i),
      .ptr_val_i   (ptr_val_i),
      .dev_sel_i   (dev_sel_i),
      .dev_val_i   (dev_val_i),
      .hw_sub_i    (hw_sub_i),
      .byte_valid_i(byte_valid_i),
      .abort_i     (abort_i),
      .ptr_o       (ptr_q),
      .ptr_ok_o    (ptr_ok_q),
      .sub_o       (sub_q),
      .accept_o    (accept),
      .store_o     (store_en)
   );

   lcd_bit_place #(.NCOLS(NCOLS), .PTR_W(PTR_W)) u_place (
      .base_i(ptr_q),
      .mode_i(mode),
      .col_o (bit_col),
      .row_o (bit_row)
   );

   lcd_col_ram #(.NCOLS(NCOLS), .PTR_W(PTR_W)) u_ram (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (store_en),
      .byte_i   (byte_i),
      .col_i    (bit_col),
      .row_i    (bit_row),
      .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o)
   );

endmodule

// File: rtl/lcd_ram_writer_chk.sv
module lcd_ram_writer_chk #(
   parameter int NCOLS = 40,
   parameter int SUB_W = 3,
   parameter int PTR_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode_i,
   input logic             ptr_load_i,
   input logic [PTR_W-1:0] ptr_val_i,
   input logic             dev_sel_i,
   input logic             abort_i,
   input logic [SUB_W-1:0] hw_sub_i,
   input logic [PTR_W-1:0] ptr_q,
   input logic             ptr_ok_q,
   input logic [SUB_W-1:0] sub_q,
   input logic             accept,
   input logic             store_en
);

   int               step_i;
   int               sum_i;
   logic [PTR_W-1:0] exp_ptr;
   logic             exp_wrap;
   logic [SUB_W-1:0] sub_plus;

   always_comb begin
      case (mode_i)
         2'd0:    step_i = 8;
         2'd1:    step_i = 4;
         2'd2:    step_i = 3;
         default: step_i = 2;
      endcase
      sum_i    = int'(ptr_q) + step_i;
      exp_wrap = (sum_i >= NCOLS);
      exp_ptr  = PTR_W'(sum_i % NCOLS);
      sub_plus = sub_q + 1'b1;
   end

   // R8
   abort_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> !ptr_ok_q);

   // R5
   ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_load_i && !abort_i) |=> (ptr_ok_q && ptr_q == $past(ptr_val_i)));

   // R5
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (ptr_q == $past(exp_ptr)));

   // R6
   store_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store_en |-> (ptr_ok_q && sub_q == hw_sub_i));

   // R7
   sub_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && exp_wrap && !dev_sel_i) |=> (sub_q == $past(sub_plus)));

   // R9
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!accept && !ptr_load_i && !abort_i) |=> $stable(ptr_q));

   // R9
   strobe_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_load_i || dev_sel_i || abort_i) |-> !accept);

   // R5
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr_q) < NCOLS);

endmodule

bind lcd_ram_writer lcd_ram_writer_chk #(.NCOLS(NCOLS), .SUB_W(SUB_W), .PTR_W(PTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_i    (mode_i),
   .ptr_load_i(ptr_load_i),
   .ptr_val_i (ptr_val_i),
   .dev_sel_i (dev_sel_i),
   .abort_i   (abort_i),
   .hw_sub_i  (hw_sub_i),
   .ptr_q     (ptr_q),
   .ptr_ok_q  (ptr_ok_q),
   .sub_q     (sub_q),
   .accept    (accept),
   .store_en  (store_en)
);

// File: tb/lcd_ram_writer_test.sv
module lcd_ram_writer_test;

   localparam int N  = 40;
   localparam int HW = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_i = 2'd0;
   logic       ptr_load_i = 1'b0;
   logic [5:0] ptr_val_i = '0;
   logic       dev_sel_i = 1'b0;
   logic [2:0] dev_val_i = '0;
   logic [2:0] hw_sub_i = 3'(HW);
   logic       byte_valid_i = 1'b0;
   logic [7:0] byte_i = '0;
   logic       abort_i = 1'b0;
   logic [5:0] rd_addr_i = '0;
   logic [3:0] rd_data_o;

   lcd_ram_writer uut (.*);

   always #5 clk = ~clk;

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   bit    mon_on = 0;
   string cur_req = "R10";

   logic [3:0] mdl [N];
   int  m_ptr = 0;
   bit  m_ok  = 0;
   int  m_sub = 0;

   // rotating read column, compared every clock
   always @(posedge clk) rd_addr_i <= (int'(rd_addr_i) == N-1) ? '0 : rd_addr_i + 1'b1;

   always @(negedge clk) begin
      if (rst_n && mon_on && !done) begin
         checks++;
         if (rd_data_o !== mdl[rd_addr_i]) begin
            errors++;
            $display("FAIL %s col %0d actual %h expected %h", cur_req, rd_addr_i, rd_data_o, mdl[rd_addr_i]);
         end
      end
   end

   task automatic model(input bit ab, input bit ld, input int lv, input bit ds, input int dv,
                        input bit bv, input logic [7:0] b);
      int rows = int'(mode_i) + 1;
      int adv  = (8 + rows - 1) / rows;
      if (ab) m_ok = 0;
      else if (ld) begin m_ptr = lv; m_ok = 1; end
      else if (bv && m_ok && !ds) begin
         for (int k = 0; k < 8; k++)
            if (m_sub == HW) mdl[(m_ptr + k / rows) % N][k % rows] = b[7-k];
         m_ptr = m_ptr + adv;
         if (m_ptr >= N) begin m_ptr -= N; m_sub = (m_sub + 1) % 8; end
      end
      if (ds) m_sub = dv;
   endtask

   task automatic cyc(input bit ab, input bit ld, input int lv, input bit ds, input int dv,
                      input bit bv, input logic [7:0] b);
      @(negedge clk);
      abort_i = ab; ptr_load_i = ld; ptr_val_i = 6'(lv);
      dev_sel_i = ds; dev_val_i = 3'(dv); byte_valid_i = bv; byte_i = b;
      @(posedge clk);
      model(ab, ld, lv, ds, dv, bv, b);
      #1;
      abort_i = 0; ptr_load_i = 0; dev_sel_i = 0; byte_valid_i = 0;
   endtask

   task automatic load(input int v);      cyc(0, 1, v, 0, 0, 0, 8'h00); endtask
   task automatic dsel(input int v);      cyc(0, 0, 0, 1, v, 0, 8'h00); endtask
   task automatic send(input logic [7:0] b); cyc(0, 0, 0, 0, 0, 1, b); endtask
   task automatic idle(input int n);      repeat (n) @(negedge clk); endtask

   initial begin
      #200_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired in %s", cur_req);
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < N; c++) mdl[c] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1;
      // R10: reset state, bytes before any load are dropped (pointer invalid)
      cur_req = "R10";
      send(8'hFF);
      idle(N + 2);

      // R1: static layout, MSB first along row 0
      cur_req = "R1";
      mode_i = 2'd0;
      dsel(HW); load(0);
      send(8'hA5); send(8'h3C); send(8'hFF);
      idle(N);

      // R2: 1:2 layout
      cur_req = "R2";
      mode_i = 2'd1; load(24);
      send(8'hC6); send(8'h5A); send(8'h0F);
      idle(N);

      // R4: 1:4 layout, also preloads columns for R3
      cur_req = "R4";
      mode_i = 2'd3; load(18);
      send(8'hFF); send(8'h96); send(8'h1E);
      idle(N);

      // R3: 1:3 layout, row 2 of third column retains its 1
      cur_req = "R3";
      mode_i = 2'd2; load(17);
      send(8'h00);
      send(8'hB7);
      idle(N);

      // R5: pointer step sequences in every mode with varied data
      cur_req = "R5";
      for (int m = 0; m < 4; m++) begin
         mode_i = 2'(m); load(m * 3);
         for (int i = 0; i < 5; i++) send(8'($urandom));
      end
      idle(N);

      // R6: mismatch suppresses writes but pointer advances
      cur_req = "R6";
      mode_i = 2'd1;
      dsel(2); load(0);
      send(8'h00); send(8'h00); send(8'h00);
      dsel(HW);
      send(8'hFF);
      idle(N);

      // R7: wrap continues at column 0 and increments subaddress
      cur_req = "R7";
      mode_i = 2'd0; dsel(HW); load(36);
      send(8'h96);
      send(8'hFF);
      dsel(HW - 1);
      mode_i = 2'd3; load(38);
      send(8'h5A);
      send(8'hC3);
      mode_i = 2'd2; dsel(HW); load(N - 2);
      send(8'hE7);
      idle(N);

      // R8: abort invalidates pointer until reload
      cur_req = "R8";
      mode_i = 2'd1; load(8);
      cyc(1, 0, 0, 0, 0, 0, 8'h00);
      send(8'hFF); send(8'hAA);
      load(8);
      send(8'h81);
      idle(N);

      // R9: byte coincident with strobes is discarded
      cur_req = "R9";
      mode_i = 2'd0;
      cyc(0, 1, 30, 0, 0, 1, 8'hFF);
      cyc(0, 0, 0, 1, HW, 1, 8'hFF);
      cyc(1, 1, 10, 0, 0, 1, 8'hFF);
      send(8'hFF);
      load(30);
      send(8'h00);
      idle(N);

      // R11: read port across all columns after final pattern
      cur_req = "R11";
      mode_i = 2'd3; load(0);
      for (int i = 0; i < N / 2; i++) send(8'(i * 37 + 5));
      idle(N + 2);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule